// File: doc/BRIEF.md
# Glitch-free Core Clock Mode Switch

This block derives the core machine clock from the oscillator input. In standard mode the oscillator is halved before it reaches the core. In double-speed mode the halving stage is bypassed and the oscillator drives the core directly. Software chooses the mode by writing bit 0 of an 8-bit clock control register through a simple register port. A new mode value never reaches the output select directly. It is first adopted on a rising edge of the divided clock. The output source then changes only while both candidate clocks are low, so the switch cannot produce a short pulse.

A six-state phase counter runs on the core clock, so one machine cycle lasts 12 oscillator periods in standard mode and 6 in double-speed mode. An address-latch style strobe is high during phases 0 and 3. That gives a rate of one sixth of the oscillator frequency in standard mode and one third in double-speed mode. When the core marks an external data transfer cycle, the strobe that would open phase 3 is dropped.

Top module: `clkModeSwitch`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the divider is 0, `phase` is 0, `ale` is 0, `coreClk` is low, the mode is standard and the control register reads 0.
- R2: A write with `regAddr` = 0x8F stores `regWrData[0]` as the mode bit (0 = standard, 1 = double speed). With `regAddr` = 0x8F, `regRdData` returns the mode bit in bit 0 and 0 in bits 7..1. Writes to any other address change neither the register nor the clock.
- R3: In standard mode `coreClk` has one rising edge for every two oscillator rising edges.
- R4: In double-speed mode `coreClk` has one rising edge for every oscillator rising edge.
- R5: A written mode is adopted only on an oscillator rising edge at which the divided clock rises. The output source changes only while the oscillator and the divided clock are both low, so no `coreClk` high or low time is shorter than half an oscillator period.
- R6: `phase` counts 0,1,2,3,4,5,0,... and advances once per `coreClk` rising edge, including across mode changes.
- R7: `ale` is high for exactly the core periods in which `phase` is 0 or 3. This gives one pulse per 6 oscillator periods in standard mode and one per 3 in double-speed mode.
- R8: If `xdataCycle` is high at the `coreClk` edge that enters phase 3, `ale` stays low for that phase. The phase-0 pulse is never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe, oscillator domain |
| regAddr | input | 8 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, 0 when the address does not match |
| xdataCycle | input | 1 | Core marks an external data transfer machine cycle |
| coreClk | output | 1 | Selected core clock |
| phase | output | 3 | Machine-cycle state, 0 to 5 |
| ale | output | 1 | Periodic address-latch strobe |

## Verification
Four checks run on every cycle. The adopted mode changes only when the divided clock rises. The output select changes only while the divided clock is low. The strobe appears only in phases 0 and 3. A missing phase-3 strobe is always traced back to `xdataCycle`. The bench scenarios cover what a single cycle cannot show: the edge rates of the core clock and the strobe in each mode over whole machine cycles, the dropped-pulse rate with data transfers held active, the minimum pulse width of `coreClk` across mode changes in both directions, the unbroken phase order, register decode and readback, and reset taken in double-speed mode.

// File: rtl/clkSwitchPkg.sv
`timescale 1ns/1ps
package clkSwitchPkg;
  // Select strobes passed from the control to the clock path.
  typedef struct packed {
    logic pickStd;
    logic pickFast;
  } clkSel_t;
endpackage

// File: rtl/clkSwitchCtrl.sv
`timescale 1ns/1ps
module clkSwitchCtrl
  import clkSwitchPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              divClk,
  output clkSel_t           sel
);
  logic modeReg;     // software view
  logic modeAdopted; // taken on divided-clock rise
  logic addrHit;

  assign addrHit = (regAddr == CTRL_ADDR);

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) modeReg <= 1'b0;
    else if (regWrEn && addrHit) modeReg <= regWrData[0];
  end

  // divClk low now means it rises at this same edge
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) modeAdopted <= 1'b0;
    else if (!divClk) modeAdopted <= modeReg;
  end

  // change source only while osc low and divided clock low
  always_ff @(negedge oscClk or negedge rstN) begin
    if (!rstN) begin
      sel.pickStd  <= 1'b1;
      sel.pickFast <= 1'b0;
    end else if (!divClk) begin
      sel.pickStd  <= !modeAdopted;
      sel.pickFast <= modeAdopted;
    end
  end

  always_comb begin
    regRdData = '0;
    if (addrHit) regRdData[0] = modeReg;
  end

  // R5: adoption only at a divided-clock rising edge
  p_adopt_on_div_rise_r5: assert property (@(posedge oscClk) disable iff (!rstN)
    !$stable(modeAdopted) |-> divClk);

  // R5: output source moves only while the divided clock is low
  p_select_when_low_r5: assert property (@(posedge oscClk) disable iff (!rstN)
    !$stable(sel.pickFast) |-> !divClk);
endmodule

// File: rtl/clkSwitchPath.sv
`timescale 1ns/1ps
module clkSwitchPath
  import clkSwitchPkg::*;
(
  input  logic    oscClk,
  input  logic    rstN,
  input  clkSel_t sel,
  output logic    divClk,
  output logic    coreClk
);
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) divClk <= 1'b0;
    else       divClk <= !divClk;
  end

  assign coreClk = (sel.pickFast & oscClk) | (sel.pickStd & divClk);
endmodule

// File: rtl/clkSwitchSeq.sv
`timescale 1ns/1ps
module clkSwitchSeq #(
  parameter int PHASE_COUNT = 6,
  localparam int PHASE_W = $clog2(PHASE_COUNT)
) (
  input  logic               coreClk,
  input  logic               rstN,
  input  logic               xdataCycle,
  output logic [PHASE_W-1:0] phase,
  output logic               ale
);
  localparam logic [PHASE_W-1:0] LAST_PH   = PHASE_W'(PHASE_COUNT - 1);
  localparam logic [PHASE_W-1:0] SECOND_PH = PHASE_W'(PHASE_COUNT / 2);

  logic [PHASE_W-1:0] phaseNext;

  always_comb begin
    phaseNext = (phase == LAST_PH) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      ale   <= 1'b0;
    end else begin
      phase <= phaseNext;
      ale   <= (phaseNext == '0) || ((phaseNext == SECOND_PH) && !xdataCycle);
    end
  end

  // R7: strobe only in the two address phases
  p_ale_phase_r7: assert property (@(posedge coreClk) disable iff (!rstN)
    ale |-> (phase == '0 || phase == SECOND_PH));

  // R8: a missing second strobe is caused by a data transfer cycle
  p_skip_cause_r8: assert property (@(posedge coreClk) disable iff (!rstN)
    (phase == SECOND_PH && !ale) |-> $past(xdataCycle));
endmodule

// File: rtl/clkModeSwitch.sv
`timescale 1ns/1ps
module clkModeSwitch
  import clkSwitchPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  parameter int PHASE_COUNT = 6,
  localparam int PHASE_W = $clog2(PHASE_COUNT)
) (
  input  logic               oscClk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               xdataCycle,
  output logic               coreClk,
  output logic [PHASE_W-1:0] phase,
  output logic               ale
);
  clkSel_t sel;
  logic    divClk;

  clkSwitchCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) uCtrl (
    .oscClk(oscClk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .divClk(divClk), .sel(sel));

  clkSwitchPath uPath (
    .oscClk(oscClk), .rstN(rstN), .sel(sel), .divClk(divClk), .coreClk(coreClk));

  clkSwitchSeq #(.PHASE_COUNT(PHASE_COUNT)) uSeq (
    .coreClk(coreClk), .rstN(rstN), .xdataCycle(xdataCycle),
    .phase(phase), .ale(ale));
endmodule

// File: tb/clkModeSwitch_test.sv
`timescale 1ns/1ps
module clkModeSwitch_test;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;

  localparam int K_CORE  = 0;
  localparam int K_ALE   = 1;
  localparam int K_RD    = 2;
  localparam int K_RUNT  = 3;
  localparam int K_PHERR = 4;
  localparam int K_PHASE = 5;
  localparam int K_ALEV  = 6;
  localparam int K_CLKV  = 7;

  typedef struct {
    int    kind;
    int    arg;
    int    expected;
    string req;
  } item_t;

  logic       oscClk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h8F;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       xdataCycle = 1'b0;
  logic       coreClk;
  logic [2:0] phase;
  logic       ale;

  int    totalChecks = 0;
  int    failChecks  = 0;
  item_t expQ[$];
  int    coreRise = 0;
  int    aleRise  = 0;
  int    runtCnt  = 0;
  int    phaseErr = 0;
  time   lastEdgeT = 0;
  time   armT = 0;
  int    prevPhase = 0;
  bit    havePrev = 0;
  bit    finished = 0;

  clkModeSwitch uut (
    .oscClk(oscClk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xdataCycle(xdataCycle),
    .coreClk(coreClk), .phase(phase), .ale(ale));

  always #(HALF) oscClk = !oscClk;

  always @(posedge coreClk) coreRise++;
  always @(posedge ale) aleRise++;
  always @(posedge rstN) armT = $time;

  // R5: pulse width monitor
  always @(coreClk) begin
    if (rstN && lastEdgeT >= armT && armT != 0 && ($time - lastEdgeT) < HALF) runtCnt++;
    lastEdgeT = $time;
  end

  // R6: phase order monitor
  always @(negedge coreClk) begin
    if (rstN) begin
      if (havePrev && phase != 3'((prevPhase + 1) % 6)) phaseErr++;
      prevPhase = phase;
      havePrev  = 1;
    end else begin
      havePrev = 0;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      int act;
      int snap;
      wait (expQ.size() > 0);
      it = expQ[0];
      act = 0;
      case (it.kind)
        K_CORE: begin
          @(negedge oscClk); snap = coreRise;
          repeat (it.arg) @(negedge oscClk);
          act = coreRise - snap;
        end
        K_ALE: begin
          @(negedge oscClk); snap = aleRise;
          repeat (it.arg) @(negedge oscClk);
          act = aleRise - snap;
        end
        K_RD:    act = int'(regRdData);
        K_RUNT:  act = runtCnt;
        K_PHERR: act = phaseErr;
        K_PHASE: act = int'(phase);
        K_ALEV:  act = int'(ale);
        default: act = int'(coreClk);
      endcase
      totalChecks++;
      if (act != it.expected) begin
        failChecks++;
        $display("FAIL %s: actual %0d expected %0d", it.req, act, it.expected);
      end
      void'(expQ.pop_front());
    end
  end

  task automatic expect_item(input int kind, input int arg, input int expected, input string req);
    item_t it;
    it.kind = kind; it.arg = arg; it.expected = expected; it.req = req;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic reg_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge oscClk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge oscClk);
    regWrEn = 1'b0; regAddr = 8'h8F;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge oscClk);
  endtask

  initial begin
    settle(3);
    // R1: reset state
    expect_item(K_PHASE, 0, 0, "R1 phase in reset");
    expect_item(K_ALEV, 0, 0, "R1 ale in reset");
    expect_item(K_CLKV, 0, 0, "R1 coreClk in reset");
    expect_item(K_RD, 0, 0, "R1 register in reset");
    @(negedge oscClk); rstN = 1'b1;
    settle(4);

    // R3: standard divide
    expect_item(K_CORE, 24, 12, "R3 std core edges");
    // R7: strobe rate in standard mode
    expect_item(K_ALE, 120, 20, "R7 std ale rate");
    // R8: dropped strobe in standard mode
    xdataCycle = 1'b1; settle(12);
    expect_item(K_ALE, 120, 10, "R8 std skip rate");
    xdataCycle = 1'b0; settle(12);

    // R2: other address has no effect
    reg_write(8'h8E, 8'h01); settle(8);
    expect_item(K_RD, 0, 0, "R2 foreign write readback");
    expect_item(K_CORE, 24, 12, "R2 foreign write keeps std");

    // R2, R4: reserved bits read 0, double speed
    reg_write(8'h8F, 8'hFF);
    expect_item(K_RD, 0, 1, "R2 reserved bits read zero");
    settle(8);
    expect_item(K_CORE, 24, 24, "R4 x2 core edges");
    expect_item(K_ALE, 60, 20, "R7 x2 ale rate");
    xdataCycle = 1'b1; settle(6);
    expect_item(K_ALE, 60, 10, "R8 x2 skip rate");
    xdataCycle = 1'b0; settle(6);

    // back to standard
    reg_write(8'h8F, 8'h00); settle(8);
    expect_item(K_CORE, 24, 12, "R3 std after switch back");
    reg_write(8'h8F, 8'h01); settle(8);
    expect_item(K_CORE, 24, 24, "R4 x2 second switch");

    // R5, R6: integrity across all switches
    expect_item(K_RUNT, 0, 0, "R5 no runt pulses");
    expect_item(K_PHERR, 0, 0, "R6 phase order");

    // R1: reset while in double speed
    @(negedge oscClk); rstN = 1'b0; settle(2);
    expect_item(K_PHASE, 0, 0, "R1 phase after reset");
    expect_item(K_RD, 0, 0, "R1 register after reset");
    expect_item(K_ALEV, 0, 0, "R1 ale after reset");
    @(negedge oscClk); rstN = 1'b1; settle(6);
    expect_item(K_CORE, 24, 12, "R1 std after reset");
    expect_item(K_RUNT, 0, 0, "R5 no runt after reset");

    finished = 1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      totalChecks++; failChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end
endmodule